// File: doc/BRIEF.md
# Converter output offset, clip and load-timing stage

This block sits behind a 14-bit converter core. Each completed conversion arrives as a signed raw code that may lie below zero or above full scale. The block adds a signed offset that a host has programmed, then limits the sum in one of two ways. With clipping on, it saturates the sum to the 14-bit code range. With clipping off, it passes the sum on as a wider two's-complement value whose upper bits carry the overrange.

The host programs the offset with a single 15-bit bus word. The block rejects words that are malformed or out of range.

Two mode pins choose when the output data register takes a new result:
- **Immediate mode:** the register loads straight after the conversion beat.
- **Deferred mode:** the result is held back until the next start-of-conversion falling edge, which adds one sample of latency.

Reads are plain strobes. A read made while a conversion is running is not serviced with fresh data.

Conversion results arrive on a valid/ready stream. `cnv_ready` is high in both legal modes, and every beat with `cnv_valid` high is taken in that cycle. In a reserved mode `cnv_ready` goes low. Beats offered during that time are neither consumed nor remembered, so the producer must hold or drop them.

Top module: `adc_offset_clip`

## Requirements
- R1: After reset, `dout` and `rd_resp_data` are 0, `rd_resp_valid`, `mode_error` and `read_during_conv` are 0, and the programmed offset is 0.
- R2: An offset write is accepted when `off_wr_word[14:12]` is 000 and the 12-bit two's-complement field `off_wr_word[11:0]` lies in −1310..+1310. Any other write leaves the offset unchanged.
- R3: With `clip_en` = 1, the loaded result is raw + offset limited to 0..16383, so bits [15:14] are 0.
- R4: With `clip_en` = 0, the loaded result is raw + offset as a 16-bit two's-complement value, saturated only at −32768 and +32767.
- R5: With `mode_sel` = 01 (immediate), `dout` shows the result of an accepted beat in the cycle after that beat.
- R6: With `mode_sel` = 10 (deferred), an accepted beat is only staged. `dout` changes only in the cycle after `convst_n` is sampled low following a sampled high, and it then takes the last staged result.
- R7: With `mode_sel` = 00 or 11 (reserved), `cnv_ready` is 0 and `dout` holds. `mode_error` is 1 from the cycle after the reserved value is seen, and returns to 0 one cycle after a legal mode is selected.
- R8: `rd_req` with `busy` = 0 gives `rd_resp_valid` = 1 in the next cycle, with `rd_resp_data` equal to the `dout` value at the request.
- R9: `rd_req` with `busy` = 1 still pulses `rd_resp_valid`, but `rd_resp_data` repeats the previous response. It also sets `read_during_conv`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 2 | Load mode: 01 immediate, 10 deferred, 00/11 reserved |
| clip_en | input | 1 | 1 saturates to 0..16383, 0 keeps the overrange |
| off_wr_en | input | 1 | Offset write strobe |
| off_wr_word | input | 15 | Offset write word: [14:12] must be 0, [11:0] is the signed offset |
| busy | input | 1 | Conversion in progress |
| convst_n | input | 1 | Start of conversion, active low; its falling edge triggers deferred loads |
| cnv_valid | input | 1 | Conversion result beat valid |
| cnv_ready | output | 1 | Beat accepted (low in reserved modes) |
| cnv_code | input | 16 | Signed raw conversion code |
| dout | output | 16 | Output data register |
| rd_req | input | 1 | Read strobe |
| rd_resp_valid | output | 1 | Read response valid, one cycle after `rd_req` |
| rd_resp_data | output | 16 | Read response data |
| mode_error | output | 1 | Reserved mode selected |
| read_during_conv | output | 1 | Sticky flag: a read was made while busy |

## Verification
A wrong offset register shows up on `dout` in the cycle after the next accepted beat, as a value shifted by the error. Its boundary values are probed with codes whose expected sums are known exactly.

A fault in the clip or overrange path shows as wrong upper bits or a wrong saturation point on that same load. A wrong staged value or a wrong edge detector in deferred mode shows one cycle after a `convst_n` falling edge, or as a `dout` change where none is due.

Faults in the read path appear on `rd_resp_data` one cycle after a strobe, in particular when a strobe is made during `busy`.

// File: rtl/adc_oc_pkg.sv
package adc_oc_pkg;
  localparam int CODE_W    = 14;
  localparam int OUT_W     = CODE_W + 2;
  localparam int OFF_W     = 12;
  localparam int BUS_W     = 15;
  localparam int OFF_LIMIT = 1310;

  typedef enum logic [1:0] {
    LMODE_RSV_LO = 2'b00,
    LMODE_IMM    = 2'b01,
    LMODE_DEFER  = 2'b10,
    LMODE_RSV_HI = 2'b11
  } load_mode_e;
endpackage

// File: rtl/adc_oc_offset_reg.sv
module adc_oc_offset_reg #(
  parameter int BUS_W     = adc_oc_pkg::BUS_W,
  parameter int OFF_W     = adc_oc_pkg::OFF_W,
  parameter int OFF_LIMIT = adc_oc_pkg::OFF_LIMIT
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [BUS_W-1:0]        wr_word,
  output logic signed [OFF_W-1:0] offset_q
);
  localparam int TAG_W = BUS_W - OFF_W;

  logic signed [OFF_W-1:0] cand;
  logic                    tag_ok;
  logic                    range_ok;

  assign cand     = wr_word[OFF_W-1:0];
  assign tag_ok   = (wr_word[BUS_W-1:OFF_W] == {TAG_W{1'b0}});
  assign range_ok = (int'(cand) <= OFF_LIMIT) && (int'(cand) >= -OFF_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          offset_q <= '0;
    else if (wr_en && tag_ok && range_ok) offset_q <= cand;
  end

  AST_OFFSET_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(offset_q) <= OFF_LIMIT) && (int'(offset_q) >= -OFF_LIMIT)); // R2

  AST_BAD_TAG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !tag_ok) |=> $stable(offset_q)); // R2
endmodule

// File: rtl/adc_oc_arith.sv
module adc_oc_arith #(
  parameter int CODE_W = adc_oc_pkg::CODE_W,
  parameter int OUT_W  = adc_oc_pkg::OUT_W,
  parameter int OFF_W  = adc_oc_pkg::OFF_W
) (
  input  logic signed [OUT_W-1:0] raw,
  input  logic signed [OFF_W-1:0] offset,
  input  logic                    clip_en,
  output logic [OUT_W-1:0]        result
);
  localparam int SUM_W = OUT_W + 1;
  localparam logic signed [SUM_W-1:0] CLIP_HI = SUM_W'((1 << CODE_W) - 1);
  localparam logic signed [SUM_W-1:0] WIDE_HI = SUM_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] WIDE_LO = ~WIDE_HI;

  logic signed [SUM_W-1:0] sum;
  logic signed [SUM_W-1:0] lim;

  always_comb begin
    sum = SUM_W'(raw) + SUM_W'(offset);
    if (clip_en) begin
      if (sum[SUM_W-1])     lim = '0;
      else if (sum > CLIP_HI) lim = CLIP_HI;
      else                  lim = sum;
    end else begin
      if (sum > WIDE_HI)      lim = WIDE_HI;
      else if (sum < WIDE_LO) lim = WIDE_LO;
      else                    lim = sum;
    end
    result = lim[OUT_W-1:0];
  end
endmodule

// File: rtl/adc_oc_outreg.sv
module adc_oc_outreg
  import adc_oc_pkg::*;
#(
  parameter int OUT_W = adc_oc_pkg::OUT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             cnv_valid,
  output logic             cnv_ready,
  input  logic [OUT_W-1:0] result,
  input  logic             busy,
  input  logic             convst_n,
  input  logic             rd_req,
  output logic [OUT_W-1:0] dout,
  output logic             mode_error,
  output logic             rd_resp_valid,
  output logic [OUT_W-1:0] rd_resp_data,
  output logic             read_during_conv
);
  load_mode_e      mode;
  logic            is_imm, is_def, reserved, fire, cs_q, cs_fall;
  logic [OUT_W-1:0] pend;

  assign mode      = load_mode_e'(mode_sel);
  assign is_imm    = (mode == LMODE_IMM);
  assign is_def    = (mode == LMODE_DEFER);
  assign reserved  = !(is_imm || is_def);
  assign cnv_ready = !reserved;
  assign fire      = cnv_valid && cnv_ready;
  assign cs_fall   = cs_q && !convst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b1;
      pend <= '0;
      dout <= '0;
      mode_error <= 1'b0;
    end else begin
      cs_q <= convst_n;
      mode_error <= reserved;
      if (is_imm && fire) dout <= result;
      if (is_def) begin
        if (fire)    pend <= result;
        if (cs_fall) dout <= pend;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_resp_valid    <= 1'b0;
      rd_resp_data     <= '0;
      read_during_conv <= 1'b0;
    end else begin
      rd_resp_valid <= rd_req;
      if (rd_req) begin
        if (busy) read_during_conv <= 1'b1;
        else      rd_resp_data     <= dout;
      end
    end
  end

  AST_CLIP_RANGE_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (is_imm && fire && result[OUT_W-1]) |=> dout[OUT_W-1]); // R4

  AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    reserved |=> $stable(dout)); // R7

  AST_DEFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (is_def && !cs_fall) |=> $stable(dout)); // R6

  AST_BUSY_READ_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && busy) |=> $stable(rd_resp_data)); // R9

  AST_STICKY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    read_during_conv |=> read_during_conv); // R9

  AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !busy) |=> (rd_resp_valid && rd_resp_data == $past(dout))); // R8
endmodule

// File: rtl/adc_offset_clip.sv
module adc_offset_clip
  import adc_oc_pkg::*;
#(
  parameter int CODE_W_P = adc_oc_pkg::CODE_W,
  parameter int OUT_W_P  = adc_oc_pkg::OUT_W,
  parameter int OFF_W_P  = adc_oc_pkg::OFF_W,
  parameter int BUS_W_P  = adc_oc_pkg::BUS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_sel,
  input  logic               clip_en,
  input  logic               off_wr_en,
  input  logic [BUS_W_P-1:0] off_wr_word,
  input  logic               busy,
  input  logic               convst_n,
  input  logic               cnv_valid,
  output logic               cnv_ready,
  input  logic [OUT_W_P-1:0] cnv_code,
  output logic [OUT_W_P-1:0] dout,
  input  logic               rd_req,
  output logic               rd_resp_valid,
  output logic [OUT_W_P-1:0] rd_resp_data,
  output logic               mode_error,
  output logic               read_during_conv
);
  logic signed [OFF_W_P-1:0] offset_q;
  logic [OUT_W_P-1:0]        result;

  adc_oc_offset_reg #(.BUS_W(BUS_W_P), .OFF_W(OFF_W_P), .OFF_LIMIT(OFF_LIMIT)) u_off (
    .clk(clk), .rst_n(rst_n), .wr_en(off_wr_en), .wr_word(off_wr_word),
    .offset_q(offset_q)
  );

  adc_oc_arith #(.CODE_W(CODE_W_P), .OUT_W(OUT_W_P), .OFF_W(OFF_W_P)) u_arith (
    .raw($signed(cnv_code)), .offset(offset_q), .clip_en(clip_en), .result(result)
  );

  adc_oc_outreg #(.OUT_W(OUT_W_P)) u_out (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cnv_valid(cnv_valid),
    .cnv_ready(cnv_ready), .result(result), .busy(busy), .convst_n(convst_n),
    .rd_req(rd_req), .dout(dout), .mode_error(mode_error),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .read_during_conv(read_during_conv)
  );

  AST_CLIP_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b01 && cnv_valid && clip_en) |=> (dout[OUT_W_P-1:CODE_W_P] == '0)); // R3
endmodule

// File: tb/adc_offset_clip_tb.sv
module adc_offset_clip_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = 2'b01;
  logic        clip_en = 1'b1;
  logic        off_wr_en = 1'b0;
  logic [14:0] off_wr_word = '0;
  logic        busy = 1'b0;
  logic        convst_n = 1'b1;
  logic        cnv_valid = 1'b0;
  logic        cnv_ready;
  logic [15:0] cnv_code = '0;
  logic [15:0] dout;
  logic        rd_req = 1'b0;
  logic        rd_resp_valid;
  logic [15:0] rd_resp_data;
  logic        mode_error;
  logic        read_during_conv;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  adc_offset_clip u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .clip_en(clip_en),
    .off_wr_en(off_wr_en), .off_wr_word(off_wr_word), .busy(busy),
    .convst_n(convst_n), .cnv_valid(cnv_valid), .cnv_ready(cnv_ready),
    .cnv_code(cnv_code), .dout(dout), .rd_req(rd_req),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .mode_error(mode_error), .read_during_conv(read_during_conv)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0d (0x%04h) exp=%0d (0x%04h)", req, got, got, exp, exp);
    end
  endtask

  task automatic wr_off(input logic [14:0] w);
    @(negedge clk); off_wr_en = 1'b1; off_wr_word = w;
    @(negedge clk); off_wr_en = 1'b0;
  endtask

  task automatic cnv(input logic [15:0] c);
    @(negedge clk); cnv_valid = 1'b1; cnv_code = c;
    @(negedge clk); cnv_valid = 1'b0;
  endtask

  task automatic convst_pulse();
    @(negedge clk); convst_n = 1'b0;
    @(negedge clk); convst_n = 1'b1;
  endtask

  task automatic rd();
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 dout", dout, 16'd0);
    check("R1 resp_data", rd_resp_data, 16'd0);
    check("R1 resp_valid", {15'd0, rd_resp_valid}, 16'd0);
    check("R1 mode_error", {15'd0, mode_error}, 16'd0);
    check("R1 read_during_conv", {15'd0, read_during_conv}, 16'd0);
    clip_en = 1'b0;
    cnv(16'd1234);
    check("R1 zero offset", dout, 16'd1234);
  endtask

  task automatic t_clip();
    mode_sel = 2'b01; clip_en = 1'b1;
    wr_off(15'h0E00);
    cnv(16'd512);   check("R3 low clip", dout, 16'd0);
    cnv(16'd15358); check("R3 mid R5", dout, 16'd14846);
    cnv(16'd16383); check("R3 top", dout, 16'd15871);
    cnv(16'd17695); check("R3 high clip", dout, 16'd16383);
    cnv(16'hFF38);  check("R3 negative raw", dout, 16'd0);
  endtask

  task automatic t_unclip();
    clip_en = 1'b0;
    cnv(16'hFAE1);  check("R4 below zero", dout, 16'hF8E1);
    cnv(16'd17695); check("R4 overrange", dout, 16'd17183);
    wr_off(15'h0400);
    cnv(16'd17695); check("R4 overrange pos", dout, 16'd18719);
    cnv(16'h7FFF);  check("R4 wide sat", dout, 16'h7FFF);
  endtask

  task automatic t_bad_writes();
    clip_en = 1'b1;
    wr_off(15'h1400); cnv(16'd0); check("R2 tag set ignored", dout, 16'd1024);
    wr_off(15'h051F); cnv(16'd0); check("R2 +1311 ignored", dout, 16'd1024);
    wr_off(15'h0AE1); cnv(16'd0); check("R2 -1311 ignored", dout, 16'd1024);
    wr_off(15'h051E); cnv(16'd0); check("R2 +1310 taken", dout, 16'd1310);
    wr_off(15'h0AE2); cnv(16'd2000); check("R2 -1310 taken", dout, 16'd690);
  endtask

  task automatic t_defer();
    wr_off(15'h0000);
    mode_sel = 2'b10;
    cnv(16'd100); check("R6 no load on beat", dout, 16'd690);
    cnv(16'd200); check("R6 still held", dout, 16'd690);
    convst_pulse(); check("R6 load on fall", dout, 16'd200);
    cnv(16'd300); check("R6 held again", dout, 16'd200);
    convst_pulse(); check("R6 one-sample latency", dout, 16'd300);
  endtask

  task automatic t_reserved();
    @(negedge clk); mode_sel = 2'b00; #1;
    check("R7 ready low 00", {15'd0, cnv_ready}, 16'd0);
    cnv(16'd5000);
    check("R7 hold 00", dout, 16'd300);
    check("R7 mode_error 00", {15'd0, mode_error}, 16'd1);
    @(negedge clk); mode_sel = 2'b11; #1;
    check("R7 ready low 11", {15'd0, cnv_ready}, 16'd0);
    convst_pulse();
    check("R7 hold 11", dout, 16'd300);
    check("R7 mode_error 11", {15'd0, mode_error}, 16'd1);
    @(negedge clk); mode_sel = 2'b01;
    @(negedge clk);
    check("R7 mode_error clears", {15'd0, mode_error}, 16'd0);
    cnv(16'd5000); check("R7 R5 resumes", dout, 16'd5000);
  endtask

  task automatic t_read();
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    check("R8 resp valid", {15'd0, rd_resp_valid}, 16'd1);
    check("R8 resp data", rd_resp_data, 16'd5000);
    check("R9 flag clear", {15'd0, read_during_conv}, 16'd0);
    cnv(16'd6000);
    @(negedge clk); busy = 1'b1; rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    check("R9 resp valid busy", {15'd0, rd_resp_valid}, 16'd1);
    check("R9 replay data", rd_resp_data, 16'd5000);
    check("R9 flag set", {15'd0, read_during_conv}, 16'd1);
    busy = 1'b0;
    cnv(16'd7000);
    rd();
    check("R9 R8 fresh data", rd_resp_data, 16'd7000);
    check("R9 flag sticky", {15'd0, read_during_conv}, 16'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clip();
    t_unclip();
    t_bad_writes();
    t_defer();
    t_reserved();
    t_read();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired got=hang exp=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule